// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of binary lock flags that two independent agents, called left and right, share. Each agent claims a shared resource in two steps. It writes a request to one flag, then reads that flag back to learn whether it now owns the token. It gives the resource up by writing a release. Each flag keeps one request latch per side and an owner record. The owner record grants the token to at most one side at a time. When the owner releases while the other side still has a request latched, the token moves straight to that side.

The block is synchronous to one clock and has an active-high synchronous reset. Each side has a flag-select strobe, a memory-enable input, a write strobe, a flag index and a single write-data bit. Each side returns a read-data word of identical bits. An access counts only when the flag select is high and the memory enable is low. Read data is registered. It shows the owner state as it stood at the clock edge that captured the access.

Top module: `sem_bank`

## Requirements
- R1: After reset every flag is free with no latched requests, and both read-data outputs are all ones.
- R2: The index input picks one of NUM_FLAGS (default 8) flags. Each flag's requests and owner are independent of the others.
- R3: A write with data bit 0 latches a request from that side. If the flag has no owner, the requesting side becomes owner. Reading a flag returns all zeros to its owner and all ones to the other side.
- R4: A write with data bit 1 clears that side's request. An owner loses the token only through its own release write.
- R5: When the owner releases while the other side has a request latched, the other side becomes owner at the same clock edge. A request made while the other side owns the flag stays latched, and the requester keeps reading all ones until it is handed the token.
- R6: When both sides request a free flag at the same edge, the left side becomes owner. The two sides never own a flag together.
- R7: An access made with the memory enable high is ignored. It changes no request latch or owner, and the read data that follows is all ones.
- R8: Read data is registered. After the edge that captures a valid access, it shows all zeros if that side owned the indexed flag before the edge, and all ones otherwise. A write becomes visible to a read made in the next cycle. With no valid access, read data is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left flag-access select |
| l_mem_en | input | 1 | Left memory enable; must be low for a flag access |
| l_wr | input | 1 | Left write strobe |
| l_idx | input | IDX_W | Left flag index |
| l_wd | input | 1 | Left write bit (0 request, 1 release) |
| l_rd | output | DATA_W | Left read data, all bits equal |
| r_sel | input | 1 | Right flag-access select |
| r_mem_en | input | 1 | Right memory enable; must be low for a flag access |
| r_wr | input | 1 | Right write strobe |
| r_idx | input | IDX_W | Right flag index |
| r_wd | input | 1 | Right write bit (0 request, 1 release) |
| r_rd | output | DATA_W | Right read data, all bits equal |

## Verification
The assertions check these properties on every cycle:
- The two sides never own a flag together.
- A side gains a flag only while its own request is latched.
- A side loses a flag only after its own release write.
- An ignored or absent access leaves all ones on the read port.
- Read data is all ones right after reset.

Only the directed scenarios can show the following:
- The two-step claim sequence.
- The handoff at release.
- Left priority under a same-cycle request.
- Per-index independence.
- The one-cycle visibility of a write.

Each of these needs a particular order of stimulus before its result exists.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port.sv
module sem_port #(
  parameter int NUM_FLAGS = 8,
  parameter int IDX_W     = 3,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 mem_en,
  input  logic                 wr,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 wd,
  input  logic [NUM_FLAGS-1:0] tok,
  output logic [NUM_FLAGS-1:0] wr_mask,
  output logic                 wr_val,
  output logic [DATA_W-1:0]    rdata
);
  logic valid;
  logic in_range;
  logic own_hit;

  assign valid    = sel & ~mem_en;
  assign in_range = (int'(idx) < NUM_FLAGS);
  assign wr_val   = wd;

  always_comb begin
    wr_mask = '0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      if (valid && wr && (int'(idx) == i)) wr_mask[i] = 1'b1;
    end
  end

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      if (int'(idx) == i) own_hit = tok[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '1;
    else if (valid && in_range && own_hit) rdata <= '0;
    else rdata <= '1;
  end
endmodule

// File: rtl/sem_flag.sv
module sem_flag
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_l,
  input  logic wd_l,
  input  logic wr_r,
  input  logic wd_r,
  output logic req_l_n,
  output logic req_r_n,
  output logic tok_l,
  output logic tok_r
);
  logic   rel_l, rel_r;
  logic   nxt_l, nxt_r;
  owner_e owner, owner_nxt;

  assign nxt_l = wr_l ? wd_l : rel_l;
  assign nxt_r = wr_r ? wd_r : rel_r;

  always_comb begin
    if (owner == OWN_LEFT && !nxt_l)       owner_nxt = OWN_LEFT;
    else if (owner == OWN_RIGHT && !nxt_r) owner_nxt = OWN_RIGHT;
    else if (!nxt_l)                       owner_nxt = OWN_LEFT;
    else if (!nxt_r)                       owner_nxt = OWN_RIGHT;
    else                                   owner_nxt = OWN_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_l <= 1'b1;
      rel_r <= 1'b1;
      owner <= OWN_NONE;
    end else begin
      rel_l <= nxt_l;
      rel_r <= nxt_r;
      owner <= owner_nxt;
    end
  end

  assign req_l_n = rel_l;
  assign req_r_n = rel_r;
  assign tok_l   = (owner == OWN_LEFT);
  assign tok_r   = (owner == OWN_RIGHT);
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_mem_en,
  input  logic              l_wr,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic              l_wd,
  output logic [DATA_W-1:0] l_rd,
  input  logic              r_sel,
  input  logic              r_mem_en,
  input  logic              r_wr,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic              r_wd,
  output logic [DATA_W-1:0] r_rd
);
  logic [NUM_FLAGS-1:0] tok_l, tok_r, rel_l, rel_r;
  logic [NUM_FLAGS-1:0] wm_l, wm_r;
  logic                 wv_l, wv_r;

  sem_port #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_left (
    .clk(clk), .rst(rst), .sel(l_sel), .mem_en(l_mem_en), .wr(l_wr),
    .idx(l_idx), .wd(l_wd), .tok(tok_l), .wr_mask(wm_l), .wr_val(wv_l),
    .rdata(l_rd)
  );

  sem_port #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_right (
    .clk(clk), .rst(rst), .sel(r_sel), .mem_en(r_mem_en), .wr(r_wr),
    .idx(r_idx), .wd(r_wd), .tok(tok_r), .wr_mask(wm_r), .wr_val(wv_r),
    .rdata(r_rd)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag u_flag (
      .clk(clk), .rst(rst),
      .wr_l(wm_l[g]), .wd_l(wv_l), .wr_r(wm_r[g]), .wd_r(wv_r),
      .req_l_n(rel_l[g]), .req_r_n(rel_r[g]),
      .tok_l(tok_l[g]), .tok_r(tok_r[g])
    );
  end
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 l_sel,
  input logic                 l_mem_en,
  input logic                 l_wr,
  input logic [IDX_W-1:0]     l_idx,
  input logic                 l_wd,
  input logic [DATA_W-1:0]    l_rd,
  input logic                 r_sel,
  input logic                 r_mem_en,
  input logic                 r_wr,
  input logic [IDX_W-1:0]     r_idx,
  input logic                 r_wd,
  input logic [DATA_W-1:0]    r_rd,
  input logic [NUM_FLAGS-1:0] tok_l,
  input logic [NUM_FLAGS-1:0] tok_r,
  input logic [NUM_FLAGS-1:0] rel_l,
  input logic [NUM_FLAGS-1:0] rel_r
);
  AST_RESET_FREE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (l_rd == '1 && r_rd == '1)); // R1

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
    (tok_l & tok_r) == '0); // R6

  AST_LEFT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (l_sel && l_mem_en) |=> l_rd == '1); // R7

  AST_RIGHT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (r_sel && r_mem_en) |=> r_rd == '1); // R7

  AST_LEFT_IDLE_ONES: assert property (@(posedge clk) disable iff (rst)
    !l_sel |=> l_rd == '1); // R8

  AST_RIGHT_IDLE_ONES: assert property (@(posedge clk) disable iff (rst)
    !r_sel |=> r_rd == '1); // R8

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_chk
    AST_LEFT_GAIN_REQ: assert property (@(posedge clk) disable iff (rst)
      $rose(tok_l[g]) |-> !rel_l[g]); // R3

    AST_RIGHT_GAIN_REQ: assert property (@(posedge clk) disable iff (rst)
      $rose(tok_r[g]) |-> !rel_r[g]); // R3

    AST_LEFT_LOSS_REL: assert property (@(posedge clk) disable iff (rst)
      $fell(tok_l[g]) |-> $past(l_sel && !l_mem_en && l_wr && l_wd && int'(l_idx) == g)); // R4

    AST_RIGHT_LOSS_REL: assert property (@(posedge clk) disable iff (rst)
      $fell(tok_r[g]) |-> $past(r_sel && !r_mem_en && r_wr && r_wd && int'(r_idx) == g)); // R4
  end
endmodule

bind sem_bank sem_bank_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst),
  .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_idx(l_idx), .l_wd(l_wd), .l_rd(l_rd),
  .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_idx(r_idx), .r_wd(r_wd), .r_rd(r_rd),
  .tok_l(tok_l), .tok_r(tok_r), .rel_l(rel_l), .rel_r(rel_r)
);

// File: tb/sem_bank_tb.sv
module sem_bank_tb;
  localparam int NF = 8;
  localparam int DW = 8;
  localparam int IW = 3;
  localparam logic [DW-1:0] ONES  = '1;
  localparam logic [DW-1:0] ZEROS = '0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_mem_en = 0, l_wr = 0, l_wd = 1;
  logic r_sel = 0, r_mem_en = 0, r_wr = 0, r_wd = 1;
  logic [IW-1:0] l_idx = '0, r_idx = '0;
  logic [DW-1:0] l_rd, r_rd;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sem_bank #(.NUM_FLAGS(NF), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_idx(l_idx), .l_wd(l_wd), .l_rd(l_rd),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_idx(r_idx), .r_wd(r_wd), .r_rd(r_rd)
  );

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic ls, input logic le, input logic lw, input int li, input logic ld,
                        input logic rs, input logic re, input logic rw, input int ri, input logic rd);
    l_sel = ls; l_mem_en = le; l_wr = lw; l_idx = IW'(li); l_wd = ld;
    r_sel = rs; r_mem_en = re; r_wr = rw; r_idx = IW'(ri); r_wd = rd;
    @(posedge clk); #1;
    l_sel = 0; l_mem_en = 0; l_wr = 0; r_sel = 0; r_mem_en = 0; r_wr = 0;
  endtask

  task automatic wr_left(int i, logic d);  access(1,0,1,i,d, 0,0,0,0,1); endtask
  task automatic wr_right(int i, logic d); access(0,0,0,0,1, 1,0,1,i,d); endtask

  task automatic read_both(string tag, int i, logic [DW-1:0] el, logic [DW-1:0] er);
    access(1,0,0,i,1, 1,0,0,i,1);
    check({tag, " left"}, l_rd, el);
    check({tag, " right"}, r_rd, er);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NF; i++) read_both("R1 reset free", i, ONES, ONES);
  endtask

  task automatic t_claim_and_handoff();
    wr_left(2, 0);
    check("R8 write-cycle read shows prior state", l_rd, ONES);
    read_both("R3 left owns flag 2", 2, ZEROS, ONES);
    wr_right(2, 0);
    read_both("R5 right request while left owns", 2, ZEROS, ONES);
    wr_left(2, 1);
    read_both("R5 handoff to right", 2, ONES, ZEROS);
    wr_right(2, 1);
    read_both("R4 released free", 2, ONES, ONES);
  endtask

  task automatic t_withdrawn_request();
    wr_left(1, 0);
    wr_right(1, 0);
    wr_right(1, 1);
    wr_left(1, 1);
    read_both("R4 withdrawn request gives no handoff", 1, ONES, ONES);
  endtask

  task automatic t_same_cycle();
    access(1,0,1,5,0, 1,0,1,5,0);
    read_both("R6 left wins tie", 5, ZEROS, ONES);
    wr_left(5, 1);
    read_both("R6 loser gets token on release", 5, ONES, ZEROS);
    wr_right(5, 1);
    read_both("R4 flag 5 free", 5, ONES, ONES);
  endtask

  task automatic t_independent();
    wr_left(3, 0);
    wr_right(4, 0);
    read_both("R2 flag 3", 3, ZEROS, ONES);
    read_both("R2 flag 4", 4, ONES, ZEROS);
    read_both("R2 flag 0 untouched", 0, ONES, ONES);
    wr_left(3, 1);
    wr_right(4, 1);
    read_both("R2 flag 3 free", 3, ONES, ONES);
  endtask

  task automatic t_mem_enable();
    access(1,1,1,6,0, 0,0,0,0,1);
    check("R7 ignored access reads ones", l_rd, ONES);
    read_both("R7 ignored write left flag free", 6, ONES, ONES);
    wr_left(6, 0);
    access(1,1,0,6,1, 0,0,0,0,1);
    check("R7 read with memory enable while owner", l_rd, ONES);
    read_both("R7 owner unchanged", 6, ZEROS, ONES);
    access(0,0,0,0,1, 1,1,1,6,0);
    wr_left(6, 1);
    read_both("R7 ignored right request not latched", 6, ONES, ONES);
  endtask

  task automatic t_idle();
    wr_left(7, 0);
    access(0,0,0,7,1, 0,0,0,7,1);
    check("R8 no access left ones", l_rd, ONES);
    read_both("R8 owner still reads zero", 7, ZEROS, ONES);
    wr_left(7, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check("R1 left after reset", l_rd, ONES);
    check("R1 right after reset", r_rd, ONES);
    t_reset();
    t_claim_and_handoff();
    t_withdrawn_request();
    t_same_cycle();
    t_independent();
    t_mem_enable();
    t_idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule